// File: doc/BRIEF.md
# Serial-Programmed Synthesizer Control Latches

This block is the programming front end of a frequency synthesizer. A host shifts 21-bit words in over three wires: serial data, serial clock and latch enable. When latch enable rises, the two bits received last select where the word goes. The options are the reference divider latch, the feedback divider latch and the function latch. A fourth option is an initialization word. It writes the function latch and also resets the divider chain.

The block runs on the system clock `clk_i`. The three serial pins arrive asynchronously, so they are synchronized and edge-detected in that clock domain. Besides the divider values and function bits, the block drives four control signals to the rest of the synthesizer:
- a one-cycle reset pulse to the counters;
- a counter hold;
- a charge-pump tri-state request;
- a synchronous powerdown trigger.

`chip_en_i` is a level in the system clock domain. It only gates the powerdown trigger. Latches can be written at any time, and they keep their contents while the chip is disabled.

Top module: `synth_prog_ctrl`

## Requirements
- R1: A word is 21 bits, shifted in MSB first on rising edges of `ser_clk_i`; the last bit received, C2, is word bit 0 and the one before it, C1, is word bit 1.
- R2: On a rising edge of `ser_le_i` with {C1,C2}=00, the reference latch takes word bits [15:2]; a load of 50 reads back as 50 on `r_div_o`.
- R3: With {C1,C2}=10 the feedback latch takes word bits [20:2]; a load of 4750 reads back as 4750 on `n_div_o`.
- R4: With {C1,C2}=01 the function latch takes word bits [20:2]; a latch changes only when latch enable rises and its own code is decoded.
- R5: With {C1,C2}=11 the function latch is written exactly as for 01, the other latches are unchanged, and `rst_pulse_o` is raised for one clock cycle.
- R6: The first feedback-latch load after an initialization word raises `rst_pulse_o` for one cycle. Later feedback loads raise nothing until another initialization word arrives. The pulse never lasts more than one cycle.
- R7: While `rst_pulse_o` is high, `cnt_hold_o` and `cp_tristate_o` are also high.
- R8: `pwrdn_trig_o` is high in exactly those pulse cycles in which `chip_en_i` was high at the loading edge and function bits 2 and 18 are both set.
- R9: Function bit 1 holds `cnt_hold_o` and `cp_tristate_o` high for as long as it is set, and by itself never raises `pwrdn_trig_o`.
- R10: Latches load normally while `chip_en_i` is low, and their contents survive toggling of `chip_en_i`.
- R11: After reset all latches read zero, all control outputs are low, and no initialization is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Latch enable, transfers the word on its rising edge |
| chip_en_i | input | 1 | Chip enable level, gates powerdown |
| r_div_o | output | 14 | Reference divider value |
| n_div_o | output | 19 | Feedback divider value |
| func_o | output | 19 | Function latch bits |
| rst_pulse_o | output | 1 | One-cycle counter reset pulse |
| cnt_hold_o | output | 1 | Hold counters at load point |
| cp_tristate_o | output | 1 | Charge pump tri-state request |
| pwrdn_trig_o | output | 1 | Synchronous powerdown trigger |

## Verification
Three functions can land on the same clock edge:
- the reset pulse and the powerdown trigger;
- the reset pulse and a counter hold that function bit 1 already requests.

The bench provokes the first case with initialization and armed feedback loads while function bits 2 and 18 are set. It repeats those loads with chip enable high and with it low. For the second case it loads an initialization word that also sets bit 1, and then an armed feedback load, so the pulse lands inside the hold. A behavioural model that delays the pins through the synchronizer is compared with every output on every clock. Counts of pulses and triggers per word judge the one-shot rearming.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  // {C1,C2} == word[1:0]
  typedef enum logic [1:0] {
    DST_R    = 2'b00,
    DST_F    = 2'b01,
    DST_N    = 2'b10,
    DST_INIT = 2'b11
  } dest_e;

  localparam int unsigned F_HOLD_BIT = 1;
  localparam int unsigned F_PD_A_BIT = 2;
  localparam int unsigned F_PD_B_BIT = 18;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st[0] <= '0;
    else         st[0] <= d_i;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) st[i] <= '0;
      else         st[i] <= st[i-1];
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= {word_q[WORD_W-2:0], bit_i};

  assign word_o = word_q;

  // R1: the word moves only on a detected serial clock edge
  a_r1_shift_only_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(word_q));
endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank
  import synth_prog_pkg::*;
#(
  parameter int unsigned WORD_W = 21,
  parameter int unsigned R_W    = 14,
  localparam int unsigned DATA_W = WORD_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              chip_en_i,
  output logic [R_W-1:0]    r_o,
  output logic [DATA_W-1:0] n_o,
  output logic [DATA_W-1:0] f_o,
  output logic              pulse_o,
  output logic              pd_o
);
  dest_e             dest;
  logic [DATA_W-1:0] field;
  logic [R_W-1:0]    r_q;
  logic [DATA_W-1:0] n_q, f_q, f_next;
  logic              armed_q, pulse_q, pd_q;
  logic              fire, f_wr;

  assign dest  = dest_e'(word_i[1:0]);
  assign field = word_i[WORD_W-1:2];
  assign f_wr  = load_i && (dest == DST_F || dest == DST_INIT);
  assign f_next = f_wr ? field : f_q;
  assign fire  = load_i && (dest == DST_INIT || (dest == DST_N && armed_q));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      r_q     <= '0;
      n_q     <= '0;
      f_q     <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      unique case (dest)
        DST_R:    r_q <= field[R_W-1:0];
        DST_N:    begin n_q <= field; armed_q <= 1'b0; end
        DST_F:    f_q <= field;
        DST_INIT: begin f_q <= field; armed_q <= 1'b1; end
      endcase
    end

  // pulse and powerdown see the function bits in force after this load
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      pulse_q <= fire;
      pd_q    <= fire && chip_en_i && f_next[F_PD_A_BIT] && f_next[F_PD_B_BIT];
    end

  assign r_o     = r_q;
  assign n_o     = n_q;
  assign f_o     = f_q;
  assign pulse_o = pulse_q;
  assign pd_o    = pd_q;

  a_r4_latches_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(r_q) && $stable(n_q) && $stable(f_q)));

  a_r6_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  a_r6_unarmed_n_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && dest == DST_N && !armed_q) |=> !pulse_q);

  a_r8_pd_needs_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> (pulse_q && f_q[F_PD_A_BIT] && f_q[F_PD_B_BIT] && $past(chip_en_i)));
endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
#(
  parameter int unsigned WORD_W      = 21,
  parameter int unsigned R_W         = 14,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W = WORD_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_le_i,
  input  logic              chip_en_i,
  output logic [R_W-1:0]    r_div_o,
  output logic [DATA_W-1:0] n_div_o,
  output logic [DATA_W-1:0] func_o,
  output logic              rst_pulse_o,
  output logic              cnt_hold_o,
  output logic              cp_tristate_o,
  output logic              pwrdn_trig_o
);
  logic [2:0]        pins_s;
  logic              sclk_prev, le_prev;
  logic              shift, load;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] f;
  logic              pulse;

  sp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_le_i, ser_data_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_prev <= 1'b0;
      le_prev   <= 1'b0;
    end else begin
      sclk_prev <= pins_s[0];
      le_prev   <= pins_s[2];
    end

  assign shift = pins_s[0] && !sclk_prev;
  assign load  = pins_s[2] && !le_prev;

  sp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .bit_i  (pins_s[1]),
    .word_o (word)
  );

  sp_latch_bank #(.WORD_W(WORD_W), .R_W(R_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .word_i   (word),
    .chip_en_i(chip_en_i),
    .r_o      (r_div_o),
    .n_o      (n_div_o),
    .f_o      (f),
    .pulse_o  (pulse),
    .pd_o     (pwrdn_trig_o)
  );

  assign func_o        = f;
  assign rst_pulse_o   = pulse;
  assign cnt_hold_o    = pulse || f[F_HOLD_BIT];
  assign cp_tristate_o = pulse || f[F_HOLD_BIT];

  a_r7_pulse_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> (cnt_hold_o && cp_tristate_o));

  a_r9_bit1_no_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_o[F_HOLD_BIT] && !rst_pulse_o) |-> (cnt_hold_o && !pwrdn_trig_o));
endmodule

// File: tb/synth_prog_ctrl_test.sv
module synth_prog_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0, ce = 1'b0;
  logic [13:0] r_div;
  logic [18:0] n_div, func;
  logic pulse, hold, tri_o, pd;

  int checks = 0, fails = 0, cycles = 0;
  int pulse_cnt = 0, pd_cnt = 0;

  always #5 clk = ~clk;

  synth_prog_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
    .ser_le_i(le), .chip_en_i(ce), .r_div_o(r_div), .n_div_o(n_div),
    .func_o(func), .rst_pulse_o(pulse), .cnt_hold_o(hold),
    .cp_tristate_o(tri_o), .pwrdn_trig_o(pd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: pin histories stand in for the two-stage synchronizer
  int sh[4], dh[4], lh[4];
  logic [20:0] m_word;
  int m_r, m_n, m_f, m_pulse, m_pd, m_armed;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (sh[i]) begin sh[i] = 0; dh[i] = 0; lh[i] = 0; end
      m_word = '0; m_r = 0; m_n = 0; m_f = 0; m_pulse = 0; m_pd = 0; m_armed = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin sh[i] = sh[i-1]; dh[i] = dh[i-1]; lh[i] = lh[i-1]; end
      sh[0] = int'(sclk); dh[0] = int'(sdata); lh[0] = int'(le);
      m_pulse = 0; m_pd = 0;
      if (lh[2] == 1 && lh[3] == 0) begin
        case (m_word[1:0])
          2'b00: m_r = int'(m_word[15:2]);
          2'b10: begin m_n = int'(m_word[20:2]); if (m_armed != 0) m_pulse = 1; m_armed = 0; end
          2'b01: m_f = int'(m_word[20:2]);
          default: begin m_f = int'(m_word[20:2]); m_pulse = 1; m_armed = 1; end
        endcase
        if (m_pulse != 0 && ce && m_f[2] && m_f[18]) m_pd = 1;
      end
      if (sh[2] == 1 && sh[3] == 0) m_word = {m_word[19:0], dh[2][0]};
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R2 r_div", int'(r_div), m_r);
      check("R3 n_div", int'(n_div), m_n);
      check("R4 func", int'(func), m_f);
      check("R6 pulse", int'(pulse), m_pulse);
      check("R7 hold", int'(hold), (m_pulse != 0 || m_f[1]) ? 1 : 0);
      check("R7 tristate", int'(tri_o), (m_pulse != 0 || m_f[1]) ? 1 : 0);
      check("R8 pwrdn", int'(pd), m_pd);
      if (pulse) pulse_cnt++;
      if (pd) pd_cnt++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [18:0] field, input logic [1:0] code);
    logic [20:0] w;
    w = {field, code};
    for (int i = 20; i >= 0; i--) begin
      @(negedge clk); sdata = w[i]; sclk = 1'b0;
      wait_cyc(4); sclk = 1'b1;
      wait_cyc(4);
    end
    sclk = 1'b0;
    wait_cyc(4); le = 1'b1;
    wait_cyc(4); le = 1'b0;
    wait_cyc(6);
  endtask

  localparam logic [18:0] PD_BITS = 19'h40004;

  int p0, d0;

  initial begin : watchdog
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R11 reset state
    check("R11 r_div", int'(r_div), 0);
    check("R11 func", int'(func), 0);
    check("R11 pulse", int'(pulse), 0);
    check("R11 hold", int'(hold), 0);

    p0 = pulse_cnt;
    send(19'd50, 2'b00);
    check("R2 r=50", int'(r_div), 50);
    send(19'd4750, 2'b10);
    check("R3 n=4750", int'(n_div), 4750);
    check("R6 no pulse before init", pulse_cnt - p0, 0);  // R11 nothing armed

    send(19'h5A5A1, 2'b01);
    check("R1 R4 func pattern", int'(func), 32'h5A5A1);
    check("R4 r kept", int'(r_div), 50);

    ce = 1'b1;
    p0 = pulse_cnt; d0 = pd_cnt;
    send(PD_BITS, 2'b11);
    check("R5 init pulse", pulse_cnt - p0, 1);
    check("R5 init func", int'(func), int'(PD_BITS));
    check("R5 n kept", int'(n_div), 4750);
    check("R8 pd with ce", pd_cnt - d0, 1);

    p0 = pulse_cnt; d0 = pd_cnt;
    send(19'd1234, 2'b10);
    check("R6 first n pulse", pulse_cnt - p0, 1);
    check("R8 pd on n pulse", pd_cnt - d0, 1);
    p0 = pulse_cnt;
    send(19'd4750, 2'b10);
    check("R6 second n silent", pulse_cnt - p0, 0);

    ce = 1'b0;
    p0 = pulse_cnt; d0 = pd_cnt;
    send(PD_BITS | 19'h2, 2'b11);
    check("R5 init with hold bit", pulse_cnt - p0, 1);
    check("R8 no pd ce low", pd_cnt - d0, 0);
    p0 = pulse_cnt; d0 = pd_cnt;
    send(19'd777, 2'b10);
    check("R6 armed n pulse in hold", pulse_cnt - p0, 1);
    check("R9 hold no pd", pd_cnt - d0, 0);
    check("R9 hold level", int'(hold), 1);

    // R10 load while disabled, then cycle chip enable
    d0 = pd_cnt;
    send(19'd77, 2'b00);
    ce = 1'b1; wait_cyc(10); ce = 1'b0; wait_cyc(10); ce = 1'b1; wait_cyc(5);
    check("R10 r kept", int'(r_div), 77);
    check("R10 n kept", int'(n_div), 777);
    check("R9 bit1 alone no pd", pd_cnt - d0, 0);
    check("R9 tristate level", int'(tri_o), 1);

    send(19'h0, 2'b01);
    check("R9 hold released", int'(hold), 0);

    wait_cyc(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule